// File: doc/BRIEF.md
# Match-Action Pipeline Stage

This block is one stage of a packet-processing pipeline. Each transfer on its input stream carries a complete packet header vector (PHV): a fixed set of equal-width header fields. The stage builds a lookup key from a configurable choice of those fields and searches a small ternary match table with it. The table result picks an action entry, which is a wide instruction with one sub-operation per field plus a block of action data. The stage executes every sub-operation at once and emits the edited PHV on its output stream, toward the next stage or the deparser. When no entry matches, a separate default action entry is used.

Both streams use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. Once the output asserts valid, it keeps the PHV unchanged until ready is seen. The stage holds at most two PHVs, one in each register stage. It lowers its input ready only when both stages are full and the output is stalled. PHVs leave in the order they arrived. The configuration port is a plain write strobe with a kind, an address and a data word. It loads crossbar selects, table entries and action entries.

Top module: `mat_stage`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Every table entry is invalid and every action entry is all-zero (all no-ops), so each PHV leaves unchanged. After reset, key slot s selects field s.
- R2: Field f of a PHV occupies bits [8f+7:8f]. The key has two slots, and slot s occupies key bits [8s+7:8s] and carries the field chosen by its select. A write with cfg_kind=0 and cfg_addr=s loads the select of slot s from cfg_wdata[1:0].
- R3: A table entry hits when it is valid and (key XOR value) AND mask is zero. A mask bit of 1 means the bit must match. A write with cfg_kind=1 and cfg_addr=e (0..15) loads entry e with value=cfg_wdata[15:0], mask=cfg_wdata[31:16] and valid=cfg_wdata[32]. An invalid entry never hits, even with an all-zero mask.
- R4: When several entries hit, the lowest-numbered one selects the action.
- R5: When no entry hits, the action entry at address 16 (the default action) is applied. Otherwise, the action entry with the same number as the winning table entry is applied.
- R6: An action entry is loaded with cfg_kind=2 and cfg_addr=0..16, using cfg_wdata[47:0]. For field f, instruction bits [4f+1:4f] hold the operation and bits [4f+3:4f+2] hold a source field. The operations are: 0 leaves the field unchanged; 1 sets it to action byte f; 2 adds action byte f modulo 256; 3 copies the source field. Action byte f is cfg_wdata[16+8f+7:16+8f]. Every sub-operation reads the PHV as it entered the stage.
- R7: If a PHV is accepted on an edge and out_ready is high on the next edge, the PHV is on the output after that second edge, which is a latency of two cycles. With out_ready held high, the stage accepts one PHV per cycle.
- R8: While out_valid is high and out_ready is low, out_valid and out_phv hold. When both stages are full and out_ready is low, in_ready is low. No PHV is lost, duplicated or reordered.
- R9: A PHV accepted on the same edge as a configuration write is processed with the contents from before that write. PHVs accepted on later edges see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input PHV present |
| in_ready | output | 1 | Stage can take an input PHV |
| in_phv | input | 32 | Input PHV, four 8-bit fields |
| out_valid | output | 1 | Output PHV present |
| out_ready | input | 1 | Downstream takes the output PHV |
| out_phv | output | 32 | Edited PHV |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 key select, 1 table entry, 2 action entry |
| cfg_addr | input | 5 | Slot, entry or action address |
| cfg_wdata | input | 48 | Configuration data |

## Verification
The two functions that can share a cycle are a configuration write and the acceptance of a PHV. The bench provokes this by rewriting the default action, and later invalidating a table entry, on exactly the edge where a matching or missing PHV is accepted. It judges the result by expecting that PHV to carry the old behaviour and the PHV right behind it to carry the new one. The same reference model covers long sweeps in which output back-pressure, from a pseudo-random ready pattern, overlaps with continuous input. Under those sweeps, order, hold and the stall of in_ready are checked.

// File: rtl/mat_pkg.sv
package mat_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_SET  = 2'd1,
    OP_ADD  = 2'd2,
    OP_COPY = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CFG_XBAR = 2'd0,
    CFG_CAM  = 2'd1,
    CFG_ACT  = 2'd2
  } cfg_kind_e;

  localparam int DEF_NF = 4;
  localparam int DEF_FW = 8;
  localparam int DEF_KS = 2;
  localparam int DEF_NE = 16;
endpackage

// File: rtl/mat_xbar.sv
module mat_xbar #(
  parameter int NF = 4,
  parameter int FW = 8,
  parameter int KS = 2,
  localparam int IDXW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF*FW-1:0] phv,
  input  logic [IDXW-1:0]  sel [KS],
  output logic [KS*FW-1:0] key
);
  for (genvar s = 0; s < KS; s++) begin : g_slot
    always_comb begin
      key[s*FW +: FW] = '0;
      for (int f = 0; f < NF; f++) begin
        if (sel[s] == IDXW'(f)) key[s*FW +: FW] = phv[f*FW +: FW];
      end
    end
  end
endmodule

// File: rtl/mat_tcam.sv
module mat_tcam #(
  parameter int KW = 16,
  parameter int NE = 16,
  localparam int EW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic [KW-1:0] key,
  input  logic [KW-1:0] ent_val [NE],
  input  logic [KW-1:0] ent_msk [NE],
  input  logic [NE-1:0] ent_vld,
  output logic          hit,
  output logic [EW-1:0] hit_idx
);
  logic [NE-1:0] match;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    assign match[e] = ent_vld[e] && (((key ^ ent_val[e]) & ent_msk[e]) == '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit     = 1'b1;
        hit_idx = EW'(e);
      end
    end
  end

  always_comb begin
    if (hit) begin
      // R4
      hit_match_chk: assert (match[hit_idx]);
    end else begin
      // R3
      miss_none_chk: assert (match == '0);
    end
  end
endmodule

// File: rtl/mat_alu.sv
module mat_alu
  import mat_pkg::*;
#(
  parameter int NF = 4,
  parameter int FW = 8,
  localparam int IDXW = (NF > 1) ? $clog2(NF) : 1,
  localparam int SOPW = 2 + IDXW
) (
  input  logic [NF*FW-1:0]   phv_i,
  input  logic [NF*SOPW-1:0] instr,
  input  logic [NF*FW-1:0]   adata,
  output logic [NF*FW-1:0]   phv_o
);
  for (genvar f = 0; f < NF; f++) begin : g_fld
    op_e             op;
    logic [IDXW-1:0] src;
    logic [FW-1:0]   cval;
    logic [FW-1:0]   orig;
    logic [FW-1:0]   dat;

    assign op   = op_e'(instr[f*SOPW +: 2]);
    assign src  = instr[f*SOPW + 2 +: IDXW];
    assign orig = phv_i[f*FW +: FW];
    assign dat  = adata[f*FW +: FW];

    always_comb begin
      cval = '0;
      for (int k = 0; k < NF; k++) begin
        if (src == IDXW'(k)) cval = phv_i[k*FW +: FW];
      end
    end

    always_comb begin
      unique case (op)
        OP_SET:  phv_o[f*FW +: FW] = dat;
        OP_ADD:  phv_o[f*FW +: FW] = orig + dat;
        OP_COPY: phv_o[f*FW +: FW] = cval;
        default: phv_o[f*FW +: FW] = orig;
      endcase
    end
  end
endmodule

// File: rtl/mat_stage.sv
module mat_stage
  import mat_pkg::*;
#(
  parameter int NF = DEF_NF,
  parameter int FW = DEF_FW,
  parameter int KS = DEF_KS,
  parameter int NE = DEF_NE,
  localparam int IDXW = (NF > 1) ? $clog2(NF) : 1,
  localparam int SW   = (KS > 1) ? $clog2(KS) : 1,
  localparam int EW   = (NE > 1) ? $clog2(NE) : 1,
  localparam int AW   = $clog2(NE + 1),
  localparam int KW   = KS * FW,
  localparam int SOPW = 2 + IDXW,
  localparam int IW   = NF * SOPW,
  localparam int PW   = NF * FW,
  localparam int AEW  = IW + PW,
  localparam int CFGW = (AEW > 2 * KW + 1) ? AEW : 2 * KW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PW-1:0]   in_phv,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PW-1:0]   out_phv,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_kind,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CFGW-1:0] cfg_wdata
);
  // configuration storage
  logic [IDXW-1:0] xsel    [KS];
  logic [KW-1:0]   cam_val [NE];
  logic [KW-1:0]   cam_msk [NE];
  logic [NE-1:0]   cam_vld;
  logic [AEW-1:0]  act_mem [NE+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < KS; s++) xsel[s] <= IDXW'(s % NF);
      for (int e = 0; e < NE; e++) begin
        cam_val[e] <= '0;
        cam_msk[e] <= '0;
      end
      cam_vld <= '0;
      for (int a = 0; a <= NE; a++) act_mem[a] <= '0;
    end else if (cfg_we) begin
      if (cfg_kind == CFG_XBAR && cfg_addr < AW'(KS))
        xsel[cfg_addr[SW-1:0]] <= cfg_wdata[IDXW-1:0];
      if (cfg_kind == CFG_CAM && cfg_addr < AW'(NE)) begin
        cam_val[cfg_addr[EW-1:0]] <= cfg_wdata[KW-1:0];
        cam_msk[cfg_addr[EW-1:0]] <= cfg_wdata[2*KW-1:KW];
        cam_vld[cfg_addr[EW-1:0]] <= cfg_wdata[2*KW];
      end
      if (cfg_kind == CFG_ACT && cfg_addr <= AW'(NE))
        act_mem[cfg_addr] <= cfg_wdata[AEW-1:0];
    end
  end

  // key build and lookup on the input PHV
  logic [KW-1:0] key;
  logic          hit;
  logic [EW-1:0] hit_idx;
  logic [AW-1:0] act_sel;

  mat_xbar #(.NF(NF), .FW(FW), .KS(KS)) u_xbar (
    .phv (in_phv),
    .sel (xsel),
    .key (key)
  );

  mat_tcam #(.KW(KW), .NE(NE)) u_tcam (
    .key     (key),
    .ent_val (cam_val),
    .ent_msk (cam_msk),
    .ent_vld (cam_vld),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  assign act_sel = hit ? AW'(hit_idx) : AW'(NE);

  // two-stage pipeline
  logic           s1_valid, s2_valid;
  logic [PW-1:0]  s1_phv, s2_phv;
  logic [AEW-1:0] s1_act;
  logic [PW-1:0]  alu_phv;
  logic           en1, en2;

  assign en2      = out_ready || !s2_valid;
  assign en1      = en2 || !s1_valid;
  assign in_ready = en1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_phv   <= '0;
      s1_act   <= '0;
    end else if (en1) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_phv <= in_phv;
        s1_act <= act_mem[act_sel];
      end
    end
  end

  mat_alu #(.NF(NF), .FW(FW)) u_alu (
    .phv_i (s1_phv),
    .instr (s1_act[IW-1:0]),
    .adata (s1_act[AEW-1:IW]),
    .phv_o (alu_phv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_phv   <= '0;
    end else if (en2) begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_phv <= alu_phv;
    end
  end

  assign out_valid = s2_valid;
  assign out_phv   = s2_phv;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phv)));

  // R7
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && out_valid && !out_ready) |-> !in_ready);

  // R1
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));
endmodule

// File: tb/sim_mat_stage.sv
module sim_mat_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_phv = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_phv;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [4:0]  cfg_addr = '0;
  logic [47:0] cfg_wdata = '0;

  mat_stage u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_phv(in_phv),
    .out_valid(out_valid), .out_ready(out_ready), .out_phv(out_phv),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference configuration
  logic [1:0]  m_sel [2];
  logic [15:0] m_val [NE];
  logic [15:0] m_msk [NE];
  logic        m_vld [NE];
  logic [47:0] m_act [NE+1];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  string       cur_tag = "R1";
  bit          prev_stall = 0;
  logic [31:0] prev_phv = '0;
  logic [7:0]  lfsr = 8'h5A;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] p);
    logic [15:0] key;
    logic [47:0] a;
    logic [31:0] r;
    int idx;
    key[7:0]  = p[m_sel[0]*8 +: 8];
    key[15:8] = p[m_sel[1]*8 +: 8];
    idx = NE;
    for (int e = NE - 1; e >= 0; e--)
      if (m_vld[e] && (((key ^ m_val[e]) & m_msk[e]) == 16'h0)) idx = e;
    a = m_act[idx];
    for (int f = 0; f < 4; f++) begin
      logic [1:0] op, src;
      logic [7:0] d, o;
      op  = a[f*4 +: 2];
      src = a[f*4+2 +: 2];
      d   = a[16+f*8 +: 8];
      o   = p[f*8 +: 8];
      case (op)
        2'd1: r[f*8 +: 8] = d;
        2'd2: r[f*8 +: 8] = o + d;
        2'd3: r[f*8 +: 8] = p[src*8 +: 8];
        default: r[f*8 +: 8] = o;
      endcase
    end
    return r;
  endfunction

  task automatic step(input bit v, input logic [31:0] p, input bit ordy,
                      input bit we, input logic [1:0] kind, input logic [4:0] addr,
                      input logic [47:0] data);
    @(negedge clk);
    in_valid = v; in_phv = p; out_ready = ordy;
    cfg_we = we; cfg_kind = kind; cfg_addr = addr; cfg_wdata = data;
    #1;
    if (prev_stall) chk(out_valid && out_phv == prev_phv, "R8 hold", out_phv, prev_phv);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R8 extra output", out_phv, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_phv == e, t, out_phv, e);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_phv = out_phv;
    if (in_valid && in_ready) begin
      exp_q.push_back(model(in_phv));
      tag_q.push_back(cur_tag);
    end
    if (cfg_we) begin
      if (kind == 2'd0 && addr < 5'd2) m_sel[addr[0]] = data[1:0];
      if (kind == 2'd1 && addr < 5'(NE)) begin
        m_val[addr[3:0]] = data[15:0];
        m_msk[addr[3:0]] = data[31:16];
        m_vld[addr[3:0]] = data[32];
      end
      if (kind == 2'd2 && addr <= 5'(NE)) m_act[addr] = data;
    end
  endtask

  task automatic send(input logic [31:0] p);
    step(1, p, 1, 0, 2'd0, 5'd0, 48'h0);
  endtask

  task automatic cfg(input logic [1:0] kind, input logic [4:0] addr, input logic [47:0] data);
    step(0, 32'h0, 1, 1, kind, addr, data);
  endtask

  task automatic drain;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) step(0, 32'h0, 1, 0, 2'd0, 5'd0, 48'h0);
    chk(exp_q.size() == 0, "R8 drain", 32'(exp_q.size()), 32'h0);
  endtask

  function automatic logic [47:0] act(input logic [15:0] ins, input logic [31:0] d);
    return {d, ins};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ready_ok;
    m_sel[0] = 2'd0; m_sel[1] = 2'd1;
    for (int e = 0; e < NE; e++) begin m_val[e] = '0; m_msk[e] = '0; m_vld[e] = 0; end
    for (int a = 0; a <= NE; a++) m_act[a] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 32'h0);
    chk(in_ready == 1, "R1 in_ready", 32'(in_ready), 32'h1);
    rst_n = 1'b1;

    // R1 passthrough
    cur_tag = "R1";
    for (int i = 0; i < 8; i++) send(32'h1357_9BDF * (i + 1));
    drain();

    // R7 latency
    cur_tag = "R7";
    send(32'hCAFE_0001);
    step(0, 32'h0, 1, 0, 2'd0, 5'd0, 48'h0);
    chk(out_valid == 0, "R7 one cycle", 32'(out_valid), 32'h0);
    step(0, 32'h0, 1, 0, 2'd0, 5'd0, 48'h0);
    chk(out_valid == 1, "R7 two cycles", 32'(out_valid), 32'h1);
    drain();

    // R2 crossbar: slot0 <- field2, slot1 <- field0
    cfg(2'd0, 5'd0, 48'd2);
    cfg(2'd0, 5'd1, 48'd0);
    // R3 entries
    cfg(2'd1, 5'd1, {15'h0, 1'b1, 16'h00FF, 16'h0005});
    cfg(2'd1, 5'd2, {15'h0, 1'b1, 16'h0F00, 16'h0300});
    cfg(2'd1, 5'd0, {15'h0, 1'b1, 16'hFFF0, 16'h33F0});
    cfg(2'd1, 5'd7, {15'h0, 1'b0, 16'h0000, 16'h0000});
    // R6 actions
    cfg(2'd2, 5'd1, act({4'b0011, 4'b0000, 4'b0001, 4'b0000}, 32'h0000_A100));
    cfg(2'd2, 5'd2, act({4'b0000, 4'b0000, 4'b0011, 4'b0010}, 32'h0000_00F0));
    cfg(2'd2, 5'd0, act({4'b0000, 4'b0001, 4'b0111, 4'b0011}, 32'h0000_0000));
    cfg(2'd2, 5'd16, act({4'b0010, 4'b0000, 4'b0000, 4'b0000}, 32'h0100_0000));

    // R4 overlaps
    cur_tag = "R4";
    send(32'h11F7_2233);
    send(32'h0005_4433);
    // R5 miss with wrap of add
    cur_tag = "R5";
    send(32'hFF00_0000);
    // R6 copy reads original fields
    cur_tag = "R6";
    send(32'h9905_7788);
    drain();

    // R2 R3 sweep with full throughput
    cur_tag = "R2 R3 sweep";
    ready_ok = 1;
    for (int a = 0; a < 256; a++) begin
      send({8'(a * 5), 8'(a), 8'(a * 3 + 1), 8'((a * 37 + 3) & 255)});
      if (a > 0 && !in_ready) ready_ok = 0;
    end
    chk(ready_ok, "R7 throughput", 32'(ready_ok), 32'h1);
    drain();

    // R8 back-pressure sweep
    cur_tag = "R8 sweep";
    for (int a = 0; a < 512; a++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[2] | lfsr[6], {8'(a), 8'(a >> 1), 8'(a), 8'(a * 7)},
           lfsr[0] | lfsr[1], 0, 2'd0, 5'd0, 48'h0);
    end
    drain();

    // R8 full stall
    cur_tag = "R8 stall";
    step(1, 32'h0101_0101, 0, 0, 2'd0, 5'd0, 48'h0);
    step(1, 32'h0202_0202, 0, 0, 2'd0, 5'd0, 48'h0);
    step(1, 32'h0303_0303, 0, 0, 2'd0, 5'd0, 48'h0);
    chk(in_ready == 0, "R8 in_ready low", 32'(in_ready), 32'h0);
    step(1, 32'h0303_0303, 0, 0, 2'd0, 5'd0, 48'h0);
    chk(in_ready == 0, "R8 in_ready held", 32'(in_ready), 32'h0);
    step(0, 32'h0, 1, 0, 2'd0, 5'd0, 48'h0);
    drain();

    // R9 same-cycle write of the default action
    cur_tag = "R9 old default";
    step(1, 32'h4400_0011, 1, 1, 2'd2, 5'd16, act(16'h0001, 32'h0000_0077));
    cur_tag = "R9 new default";
    send(32'h4400_0011);
    // R9 same-cycle invalidation of entry 1
    cur_tag = "R9 old entry";
    step(1, 32'h0005_0011, 1, 1, 2'd1, 5'd1, 48'h0);
    cur_tag = "R9 new entry";
    send(32'h0005_0011);
    drain();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule